// File: doc/BRIEF.md
# Filtered input capture channel

One capture channel that sits beside a free-running counter, which is outside the block. An asynchronous input pin is brought into the clock domain by a two-stage synchronizer. A digital filter then accepts a new input level only after that level has been sampled a programmable number of times in a row. When the filtered signal shows the selected edge, the present counter value is copied into a shadow register. On the next cycle it moves to the software-visible capture register, the capture flag is set, and an optional DMA request pulses. A second capture while the flag is still set also raises an over-capture flag. Software clears the capture flag by reading the captured value or by writing zero to the flag. The over-capture flag clears only on a write of zero.

The filter is a four-state machine. FS_LOW and FS_HIGH are the settled levels. FS_RISE and FS_FALL are the qualifying states, in which a run counter counts consecutive samples of the opposite level. Each transition has a name:
- low_to_rise: in FS_LOW a sample of 1 arrives, the length is greater than 1, and the run counter starts at 1.
- rise_abort: in FS_RISE a sample of 0 arrives, and the state returns to FS_LOW.
- rise_accept: the run reaches the length. This moves to FS_HIGH and emits a one-cycle rise pulse. When the length is 1, FS_LOW goes straight to FS_HIGH on this same transition.
- high_to_fall, fall_abort and fall_accept: the mirror images of the three transitions above.

Top module: `icap_channel`

## Requirements
- R1: After reset, the control register (address 0), the status register (address 1) and the capture register (address 2) all read 0, and irq and dma_req are 0.
- R2: Control register bits:
  - [1:0] channel select: any nonzero value enables capture from the pin.
  - [2] polarity: 0 captures rising edges, 1 captures falling edges.
  - [6:3] filter code.
  - [7] interrupt enable.
  - [8] DMA enable.

  A pin transition set up before clock edge k with filter length N is sampled as follows. The counter value presented at edge k+2+N is captured. The capture register then holds it after edge k+3+N, and reads of address 2 return it in bits [CW-1:0].
- R3: The capture flag (status bit 0) sets at edge k+3+N and not before. irq equals the capture flag ANDed with the interrupt enable.
- R4: A capture that completes while the capture flag is already set also sets the over-capture flag (status bit 1).
- R5: A read of address 2 clears the capture flag and leaves the over-capture flag unchanged.
- R6: A write to address 1 clears the capture flag when wdata bit 0 is 0, and clears the over-capture flag when wdata bit 1 is 0. Writing 1 to either bit has no effect.
- R7: Filter code 0 gives length 1. Code c from 1 to 15 gives length c+1, which covers 2 to 16. An active pulse shorter than the length produces no capture. A pulse of exactly the length produces a capture.
- R8: With the DMA enable set, dma_req is high for exactly one cycle per capture. The pulse is high in the same cycle in which the capture flag first reads 1.
- R9: If a capture completes in the same cycle as a software clear of the capture flag, the flag ends up set.
- R10: When channel select is nonzero, writes to address 2 are ignored. When channel select is 00, writes to address 2 load the register and pin edges capture nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_in | input | CW | Free-running counter value |
| pin_in | input | 1 | Asynchronous capture input |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| addr | input | 2 | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for addr (combinational) |
| irq | output | 1 | Capture flag AND interrupt enable |
| dma_req | output | 1 | One-cycle pulse per capture when DMA enabled |

## Verification
The assertions check several rules on every cycle:
- The filter's run counter is zero in the settled states.
- An aborted qualification returns to the settled state.
- A completed capture always leaves the flag set.
- The over-capture flag rises only while the capture flag is already set.
- A capture read clears the flag.
- The capture register holds still in capture mode when no transfer is pending.
- The DMA pulse never lasts two cycles.

Only the bench scenarios can show the rest:
- The exact capture latency and the captured counter value for every filter code and both polarities.
- The rejection of a pulse one sample short against the acceptance of a pulse of exactly the filter length.
- A clear and a capture falling in the same cycle.

// File: rtl/icap_pkg.sv
package icap_pkg;
    typedef enum logic [1:0] {
        FS_LOW  = 2'd0,
        FS_RISE = 2'd1,
        FS_HIGH = 2'd2,
        FS_FALL = 2'd3
    } filt_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_CAPT = 2'd2;

    localparam int CTRL_BITS = 9;
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/icap_filter.sv
module icap_filter
    import icap_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [CODE_W-1:0] code,
    output logic              level,
    output logic              rise,
    output logic              fall
);
    localparam int LEN_W = CODE_W + 1;

    filt_state_e      state_q, state_d;
    logic [LEN_W-1:0] run_q, run_d, need, run_inc;
    logic             rise_d, fall_d, rise_q, fall_q;

    assign need    = (code == '0) ? LEN_W'(1) : ({1'b0, code} + LEN_W'(1));
    assign run_inc = run_q + LEN_W'(1);

    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        rise_d  = 1'b0;
        fall_d  = 1'b0;
        unique case (state_q)
            FS_LOW: begin
                if (sample) begin
                    if (need == LEN_W'(1)) begin
                        state_d = FS_HIGH;
                        rise_d  = 1'b1;
                    end else begin
                        state_d = FS_RISE;
                        run_d   = LEN_W'(1);
                    end
                end
            end
            FS_RISE: begin
                if (!sample) begin
                    state_d = FS_LOW;
                    run_d   = '0;
                end else if (run_inc >= need) begin
                    state_d = FS_HIGH;
                    run_d   = '0;
                    rise_d  = 1'b1;
                end else begin
                    run_d = run_inc;
                end
            end
            FS_HIGH: begin
                if (!sample) begin
                    if (need == LEN_W'(1)) begin
                        state_d = FS_LOW;
                        fall_d  = 1'b1;
                    end else begin
                        state_d = FS_FALL;
                        run_d   = LEN_W'(1);
                    end
                end
            end
            FS_FALL: begin
                if (sample) begin
                    state_d = FS_HIGH;
                    run_d   = '0;
                end else if (run_inc >= need) begin
                    state_d = FS_LOW;
                    run_d   = '0;
                    fall_d  = 1'b1;
                end else begin
                    run_d = run_inc;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_LOW;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            rise_q <= rise_d;
            fall_q <= fall_d;
        end
    end

    assign level = (state_q == FS_HIGH) || (state_q == FS_FALL);
    assign rise  = rise_q;
    assign fall  = fall_q;

    AST_SETTLED_RUN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == FS_LOW) || (state_q == FS_HIGH)) |-> (run_q == '0)); // R7
    AST_RISE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == FS_RISE) && !sample) |=> (state_q == FS_LOW)); // R7
    AST_FALL_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == FS_FALL) && sample) |=> (state_q == FS_HIGH)); // R7
endmodule

// File: rtl/icap_channel.sv
module icap_channel
    import icap_pkg::*;
#(
    parameter int CW     = 16,
    parameter int DW     = 16,
    parameter int CODE_W = 4,
    parameter int SYNC_N = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_in,
    input  logic          pin_in,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq,
    output logic          dma_req
);
    // DW must be at least CW and at least CTRL_BITS.
    localparam int CODE_LO = 3;
    localparam int CODE_HI = CODE_LO + CODE_W - 1;

    logic [CTRL_BITS-1:0] ctrl_q;
    logic [CW-1:0]        shadow_q, preload_q;
    logic                 xfer_q, flag_q, over_q, dma_q;
    logic                 pin_sync, f_level, f_rise, f_fall;
    logic                 cap_mode, cap_now, clr_flag, clr_over, cpu_load;

    icap_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(pin_sync)
    );

    icap_filter #(.CODE_W(CODE_W)) u_filt (
        .clk(clk), .rst_n(rst_n), .sample(pin_sync),
        .code(ctrl_q[CODE_HI:CODE_LO]),
        .level(f_level), .rise(f_rise), .fall(f_fall)
    );

    assign cap_mode = (ctrl_q[1:0] != 2'b00);
    assign cap_now  = cap_mode && (ctrl_q[2] ? f_fall : f_rise);
    assign clr_flag = (rd_en && addr == ADDR_CAPT) ||
                      (wr_en && addr == ADDR_STAT && !wdata[0]);
    assign clr_over = wr_en && addr == ADDR_STAT && !wdata[1];
    assign cpu_load = wr_en && addr == ADDR_CAPT && !cap_mode;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            shadow_q  <= '0;
            preload_q <= '0;
            xfer_q    <= 1'b0;
            flag_q    <= 1'b0;
            over_q    <= 1'b0;
            dma_q     <= 1'b0;
        end else begin
            if (wr_en && addr == ADDR_CTRL) ctrl_q <= wdata[CTRL_BITS-1:0];
            xfer_q <= cap_now;
            if (cap_now) shadow_q <= cnt_in;
            if (xfer_q)        preload_q <= shadow_q;
            else if (cpu_load) preload_q <= wdata[CW-1:0];
            if (xfer_q)        flag_q <= 1'b1;
            else if (clr_flag) flag_q <= 1'b0;
            if (xfer_q && flag_q) over_q <= 1'b1;
            else if (clr_over)    over_q <= 1'b0;
            dma_q <= xfer_q && ctrl_q[8];
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_CTRL: rdata[CTRL_BITS-1:0] = ctrl_q;
            ADDR_STAT: rdata[1:0]           = {over_q, flag_q};
            ADDR_CAPT: rdata[CW-1:0]        = preload_q;
            default:   rdata                = '0;
        endcase
    end

    assign irq     = flag_q && ctrl_q[7];
    assign dma_req = dma_q;

    AST_FLAG_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_q |=> flag_q); // R9
    AST_OVER_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(over_q) |-> $past(flag_q)); // R4
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_CAPT && !xfer_q) |=> !flag_q); // R5
    AST_CAPT_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode && !xfer_q) |=> $stable(preload_q)); // R10
    AST_DMA_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> !dma_req); // R8
    AST_LEVEL_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        f_rise |-> f_level); // R7
endmodule

// File: tb/icap_channel_test.sv
module icap_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_in = '0;
    logic        pin_in = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq, dma_req;

    int stamp = 0;
    int vecs  = 0;
    int bad   = 0;
    bit done  = 0;

    icap_channel uut (
        .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .pin_in(pin_in),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .dma_req(dma_req)
    );

    always #5 clk = ~clk;

    task automatic step();
        @(negedge clk);
        stamp++;
        cnt_in = stamp[15:0];
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (stamp %0d)", req, act, exp, stamp);
        end
    endtask

    task automatic wreg(logic [1:0] a, logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rreg(logic [1:0] a, output logic [15:0] v);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        step();
        rd_en = 1'b0;
    endtask

    function automatic logic [15:0] cfg(logic [1:0] sel, logic pol, logic [3:0] code,
                                        logic ie, logic de);
        return {7'b0, de, ie, code, pol, sel};
    endfunction

    function automatic int flen(int code);
        return (code == 0) ? 1 : code + 1;
    endfunction

    task automatic prepare(logic pol, logic [3:0] code, logic ie, logic de);
        wreg(2'd0, cfg(2'b00, pol, code, ie, de));
        pin_in = pol;
        repeat (40) step();
        wreg(2'd1, 16'h0000);
        wreg(2'd0, cfg(2'b01, pol, code, ie, de));
    endtask

    task automatic sweep_one(int code, logic pol);
        logic [15:0] v;
        int n, i0;
        n = flen(code);
        prepare(pol, code[3:0], 1'b1, 1'b1);
        pin_in = ~pol;
        i0 = stamp;
        while (stamp < i0 + 3 + n) step();
        check("R3 flag not early", {31'b0, irq}, 0);
        step();
        check("R3 irq at k+3+N", {31'b0, irq}, 1);
        check("R8 dma pulse", {31'b0, dma_req}, 1);
        step();
        check("R8 dma single cycle", {31'b0, dma_req}, 0);
        rreg(2'd1, v);
        check("R3 status after capture", {16'b0, v}, 32'h1);
        rreg(2'd2, v);
        check("R2 captured value", {16'b0, v}, (i0 + 2 + n) & 32'hFFFF);
        rreg(2'd1, v);
        check("R5 read clears flag", {16'b0, v}, 32'h0);
        if (n >= 2) begin
            pin_in = pol;
            repeat (40) step();
            wreg(2'd1, 16'h0000);
            pin_in = ~pol;
            repeat (n - 1) step();
            pin_in = pol;
            repeat (30) step();
            rreg(2'd1, v);
            check("R7 short pulse rejected", {16'b0, v}, 32'h0);
            pin_in = ~pol;
            repeat (n) step();
            pin_in = pol;
            repeat (30) step();
            rreg(2'd1, v);
            check("R7 exact-length pulse accepted", {16'b0, v}, 32'h1);
        end
    endtask

    initial begin
        logic [15:0] v, prev;
        int i0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 dma", {31'b0, dma_req}, 0);
        rreg(2'd0, v); check("R1 ctrl", {16'b0, v}, 0);
        rreg(2'd1, v); check("R1 status", {16'b0, v}, 0);
        rreg(2'd2, v); check("R1 capture", {16'b0, v}, 0);

        // R10 mode 00: load allowed, edges ignored
        wreg(2'd0, cfg(2'b00, 1'b0, 4'd0, 1'b1, 1'b1));
        wreg(2'd2, 16'hA5A5);
        rreg(2'd2, v); check("R10 load in mode 00", {16'b0, v}, 32'hA5A5);
        pin_in = 1'b1; repeat (10) step(); pin_in = 1'b0; repeat (10) step();
        rreg(2'd1, v); check("R10 no capture in mode 00", {16'b0, v}, 0);
        rreg(2'd2, v); check("R10 value held in mode 00", {16'b0, v}, 32'hA5A5);
        wreg(2'd0, cfg(2'b01, 1'b0, 4'd0, 1'b1, 1'b1));
        wreg(2'd2, 16'h1234);
        rreg(2'd2, v); check("R10 write ignored in capture mode", {16'b0, v}, 32'hA5A5);

        // R2 R3 R5 R7 R8 sweep over every filter code and both polarities
        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 2; p++) sweep_one(c, p[0]);
        end

        // R4 R5 R6 over-capture
        prepare(1'b0, 4'd0, 1'b1, 1'b0);
        pin_in = 1'b1; repeat (10) step();
        pin_in = 1'b0; repeat (10) step();
        pin_in = 1'b1; repeat (10) step();
        rreg(2'd1, v); check("R4 over-capture set", {16'b0, v}, 32'h3);
        check("R8 no dma when disabled", {31'b0, dma_req}, 0);
        rreg(2'd2, prev);
        rreg(2'd1, v); check("R5 read keeps over flag", {16'b0, v}, 32'h2);
        wreg(2'd1, 16'h0003);
        rreg(2'd1, v); check("R6 writing ones no effect", {16'b0, v}, 32'h2);
        wreg(2'd1, 16'h0001);
        rreg(2'd1, v); check("R6 write zero clears over", {16'b0, v}, 32'h0);
        pin_in = 1'b0; repeat (10) step();
        pin_in = 1'b1; repeat (10) step();
        wreg(2'd1, 16'h0002);
        rreg(2'd1, v); check("R6 bit0 zero clears flag only", {16'b0, v}, 32'h0);

        // R9 capture beats clear in same cycle
        prepare(1'b0, 4'd0, 1'b1, 1'b0);
        pin_in = 1'b1;
        i0 = stamp;
        while (stamp < i0 + 3 + 1) step();
        wreg(2'd1, 16'h0000);
        rreg(2'd1, v); check("R9 capture wins over clear", {16'b0, v}, 32'h1);

        // R3 interrupt enable off
        prepare(1'b0, 4'd2, 1'b0, 1'b0);
        pin_in = 1'b1; repeat (20) step();
        check("R3 irq masked", {31'b0, irq}, 0);
        rreg(2'd1, v); check("R3 flag set while masked", {16'b0, v}, 32'h1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vecs++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end
endmodule